// File: doc/BRIEF.md
# Multi-client host transfer sequencer

This block times one transmit exchange from a numbered slot. It runs on a microsecond tick and keeps a single countdown that it reloads at each phase boundary. At those boundaries it raises one-cycle interrupt strobes. An exchange always runs a preamble and then a data phase. The host slot goes on to wait for client replies and then sends an acknowledgement. Every other slot finishes when its data phase ends.

The reply-wait length is derived from two values captured at the start pulse: the number of set bits in the client bitmask, and the reply-time value. When the preamble ends, the block also presents the header sequence field, which is the sequence register moved up by four bits.

The surrounding logic issues a start pulse together with a slot number. It then watches the strobes and the finished pulse. The listen request tells the receive path to open for client replies. Radio modulation and the writing of the frame body into memory are handled elsewhere.

Top module: `mp_xfer_seq`

## Requirements
- R1: After reset, busy, every strobe output (irq_start, irq_txend, irq_ack, listen_req, done) and seq_field are all zero.
- R2: After start, the preamble lasts pre_len ticks. On the tick that ends it, irq_start pulses for one cycle if the slot is not 5, and the data phase begins.
- R3: A transfer from slot 5 never pulses irq_start, neither at the end of its preamble nor later.
- R4: When the preamble ends, seq_field takes the value {seq_reg, 4'b0000}: the 12-bit register sits in bits 15:4 and the low four bits are zero.
- R5: For any slot other than the host slot (slot 1), the data phase lasts data_len ticks. On its last tick, irq_txend and done pulse together, and busy drops.
- R6: For the host slot, irq_txend and listen_req pulse when the data phase ends, and done stays low. A reply wait of 112 + (10 + reply_time) × popcount(client_mask) ticks follows. client_mask and reply_time are the values sampled at the start pulse. irq_start pulses again on the last tick of the wait.
- R7: After the reply wait, the acknowledgement phase lasts 128 + pre_len ticks. On its last tick, irq_txend and done pulse, and irq_ack pulses with them when replies_ok is 1 or retry_room is 0.
- R8: If replies_ok is 0 and retry_room is 1 when the acknowledgement ends, irq_ack stays low.
- R9: A start pulse that arrives while busy is high is ignored. The transfer in progress keeps its slot and timing.
- R10: A pre_len or data_len of zero gives a phase that lasts one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-microsecond enable |
| start | input | 1 | Start pulse |
| start_slot | input | 3 | Slot number taken with start |
| client_mask | input | 16 | Bitmask of expected clients |
| reply_time | input | 8 | Per-client reply spacing |
| pre_len | input | 14 | Preamble length in ticks |
| data_len | input | 14 | Data length in ticks |
| seq_reg | input | 12 | Transmit sequence number |
| replies_ok | input | 1 | All client replies arrived |
| retry_room | input | 1 | Time is left for a retry |
| busy | output | 1 | Exchange in progress |
| irq_start | output | 1 | Start-of-data / end-of-wait strobe |
| irq_txend | output | 1 | Transmission-end strobe |
| irq_ack | output | 1 | Exchange-complete strobe |
| listen_req | output | 1 | Open receive for client replies |
| done | output | 1 | Finished pulse |
| seq_field | output | 16 | Header sequence field |

## Verification
The plain-slot patterns use short and zero lengths. They show whether the phase count starts at the right tick and whether a zero length becomes one tick instead of wrapping. The host-slot runs use a four-client mask, an empty mask and a full mask. Together they separate a correct popcount-times-spacing formula from one that drops the constant or the base, and the bench changes mask and reply time after the start pulse to show that the sampled values are used. The three combinations of replies_ok and retry_room tell the completion-interrupt rule apart from a plain OR or AND. Slot 5 and a start pulse issued mid-transfer confirm that the interrupt is suppressed and that a second start is ignored.

// File: rtl/mp_seq_pkg.sv
package mp_seq_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_DATA, PH_WAIT, PH_ACK} phase_t;
  localparam int REPLY_BASE    = 112;
  localparam int REPLY_SPACING = 10;
  localparam int ACK_TICKS     = 128;
endpackage

// File: rtl/mp_reply_window.sv
module mp_reply_window #(
  parameter int NCLI   = 16,
  parameter int RT_W   = 8,
  parameter int WAIT_W = 13
) (
  input  logic [NCLI-1:0]   mask,
  input  logic [RT_W-1:0]   rtime,
  output logic [WAIT_W-1:0] wait_len
);
  import mp_seq_pkg::*;
  localparam int PC_W = $clog2(NCLI + 1);

  logic [PC_W-1:0] nclients;

  always_comb begin
    nclients = '0;
    for (int i = 0; i < NCLI; i++)
      nclients = nclients + PC_W'(mask[i]);
  end

  always_comb
    wait_len = WAIT_W'(REPLY_BASE) +
               (WAIT_W'(REPLY_SPACING) + WAIT_W'(rtime)) * WAIT_W'(nclients);
endmodule

// File: rtl/mp_phase_ctr.sv
module mp_phase_ctr #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (load)                    cnt <= load_val;
    else if (tick && cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
  end

  // a count of 0 or 1 ends on the next tick, so a zero length lasts one tick
  assign expire = tick && (cnt <= CNT_W'(1));

  // R2: one step down per tick while the phase is running
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R10: a loaded zero ends the phase on the first tick
  a_r10_zero_one_tick: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> (tick |-> expire));
endmodule

// File: rtl/mp_xfer_seq.sv
module mp_xfer_seq #(
  parameter int NCLI       = 16,
  parameter int RT_W       = 8,
  parameter int LEN_W      = 14,
  parameter int SEQ_W      = 12,
  parameter int SLOT_W     = 3,
  parameter int HOST_SLOT  = 1,
  parameter int QUIET_SLOT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [NCLI-1:0]   client_mask,
  input  logic [RT_W-1:0]   reply_time,
  input  logic [LEN_W-1:0]  pre_len,
  input  logic [LEN_W-1:0]  data_len,
  input  logic [SEQ_W-1:0]  seq_reg,
  input  logic              replies_ok,
  input  logic              retry_room,
  output logic              busy,
  output logic              irq_start,
  output logic              irq_txend,
  output logic              irq_ack,
  output logic              listen_req,
  output logic              done,
  output logic [SEQ_W+3:0]  seq_field
);
  import mp_seq_pkg::*;

  localparam int WAIT_MAX = REPLY_BASE + (REPLY_SPACING + (1 << RT_W) - 1) * NCLI;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int CNT_W    = ((WAIT_W > LEN_W) ? WAIT_W : LEN_W) + 1;

  phase_t             phase;
  logic [SLOT_W-1:0]  slot_q;
  logic [NCLI-1:0]    mask_q;
  logic [RT_W-1:0]    rt_q;
  logic [LEN_W-1:0]   pre_q, data_q;
  logic [WAIT_W-1:0]  wait_len;
  logic               expire, ld;
  logic [CNT_W-1:0]   ld_val;
  logic               is_host, is_quiet;

  assign is_host  = (slot_q == SLOT_W'(HOST_SLOT));
  assign is_quiet = (slot_q == SLOT_W'(QUIET_SLOT));
  assign busy     = (phase != PH_IDLE);

  mp_reply_window #(.NCLI(NCLI), .RT_W(RT_W), .WAIT_W(WAIT_W)) win_i (
    .mask(mask_q), .rtime(rt_q), .wait_len(wait_len));

  mp_phase_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst), .tick(tick), .load(ld), .load_val(ld_val), .expire(expire));

  always_comb begin
    ld     = 1'b0;
    ld_val = '0;
    if (phase == PH_IDLE) begin
      ld     = start;
      ld_val = CNT_W'(pre_len);
    end else if (expire) begin
      case (phase)
        PH_PRE:  begin ld = 1'b1;    ld_val = CNT_W'(data_q); end
        PH_DATA: begin ld = is_host; ld_val = CNT_W'(wait_len); end
        PH_WAIT: begin ld = 1'b1;    ld_val = CNT_W'(ACK_TICKS) + CNT_W'(pre_q); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      slot_q     <= '0;
      mask_q     <= '0;
      rt_q       <= '0;
      pre_q      <= '0;
      data_q     <= '0;
      irq_start  <= 1'b0;
      irq_txend  <= 1'b0;
      irq_ack    <= 1'b0;
      listen_req <= 1'b0;
      done       <= 1'b0;
      seq_field  <= '0;
    end else begin
      irq_start  <= 1'b0;
      irq_txend  <= 1'b0;
      irq_ack    <= 1'b0;
      listen_req <= 1'b0;
      done       <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_PRE;
          slot_q <= start_slot;
          mask_q <= client_mask;
          rt_q   <= reply_time;
          pre_q  <= pre_len;
          data_q <= data_len;
        end
        PH_PRE: if (expire) begin
          phase     <= PH_DATA;
          irq_start <= !is_quiet;
          seq_field <= {seq_reg, 4'b0000};
        end
        PH_DATA: if (expire) begin
          irq_txend <= 1'b1;
          if (is_host) begin
            phase      <= PH_WAIT;
            listen_req <= 1'b1;
          end else begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        PH_WAIT: if (expire) begin
          phase     <= PH_ACK;
          irq_start <= !is_quiet;
        end
        PH_ACK: if (expire) begin
          phase     <= PH_IDLE;
          irq_txend <= 1'b1;
          done      <= 1'b1;
          irq_ack   <= replies_ok || !retry_room;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: the quiet slot never raises the start strobe
  a_r3_quiet_slot: assert property (@(posedge clk) disable iff (rst)
    irq_start |-> !is_quiet);
  // R9: slot held steady while an exchange runs
  a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(slot_q));
  // R6: listen request only from the host slot, never with done
  a_r6_listen_host: assert property (@(posedge clk) disable iff (rst)
    listen_req |-> (is_host && !done && phase == PH_WAIT));
  // R7: completion interrupt only together with the finished pulse
  a_r7_ack_with_done: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (done && irq_txend));
  // R5: finished pulse is one cycle and leaves the block idle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));
endmodule

// File: tb/mp_xfer_seq_tb_top.sv
module mp_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, start = 1'b0;
  logic [2:0]  start_slot = '0;
  logic [15:0] client_mask = '0;
  logic [7:0]  reply_time = '0;
  logic [13:0] pre_len = '0, data_len = '0;
  logic [11:0] seq_reg = '0;
  logic        replies_ok = 1'b0, retry_room = 1'b0;
  logic        busy, irq_start, irq_txend, irq_ack, listen_req, done;
  logic [15:0] seq_field;

  int n_chk = 0, n_bad = 0;
  int c_st, c_te, c_ak, c_ls, c_dn, t_st, t_te, t_ak, t_ls, t_dn;

  always #2 clk = ~clk;

  mp_xfer_seq dut_i (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .start_slot(start_slot),
    .client_mask(client_mask), .reply_time(reply_time), .pre_len(pre_len),
    .data_len(data_len), .seq_reg(seq_reg), .replies_ok(replies_ok),
    .retry_room(retry_room), .busy(busy), .irq_start(irq_start),
    .irq_txend(irq_txend), .irq_ack(irq_ack), .listen_req(listen_req),
    .done(done), .seq_field(seq_field));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic kick(input logic [2:0] s, input int p, input int d);
    @(negedge clk);
    start = 1'b1; start_slot = s; pre_len = 14'(p); data_len = 14'(d);
    @(negedge clk);
    start = 1'b0;
  endtask

  // apply n ticks on consecutive cycles; count strobes and record the last tick index
  task automatic run_ticks(input int n);
    c_st = 0; c_te = 0; c_ak = 0; c_ls = 0; c_dn = 0;
    t_st = 0; t_te = 0; t_ak = 0; t_ls = 0; t_dn = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(posedge clk); #1;
      if (irq_start)  begin c_st++; t_st = i; end
      if (irq_txend)  begin c_te++; t_te = i; end
      if (irq_ack)    begin c_ak++; t_ak = i; end
      if (listen_req) begin c_ls++; t_ls = i; end
      if (done)       begin c_dn++; t_dn = i; end
    end
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0);
    chk("R1", "strobes", {irq_start, irq_txend, irq_ack, listen_req, done}, 0);
    chk("R1", "seq_field", seq_field, 0);
  endtask

  task automatic t_plain;
    seq_reg = 12'hA5C;
    kick(3'd2, 3, 5);
    chk("R2", "busy after start", busy, 1);
    run_ticks(3);
    chk("R2", "irq_start count", c_st, 1);
    chk("R2", "irq_start tick", t_st, 3);
    chk("R4", "seq_field", seq_field, 16'hA5C0);
    run_ticks(5);
    chk("R5", "txend tick", t_te, 5);
    chk("R5", "done tick", t_dn, 5);
    chk("R5", "listen count", c_ls, 0);
    chk("R5", "busy end", busy, 0);
  endtask

  task automatic t_quiet;
    kick(3'd5, 2, 2);
    run_ticks(4);
    chk("R3", "irq_start count", c_st, 0);
    chk("R3", "done tick", t_dn, 4);
  endtask

  task automatic t_host(input logic [15:0] m, input int rt, input logic ok,
                        input logic room, input int exp_wait, input int exp_ack);
    client_mask = m; reply_time = 8'(rt); replies_ok = ok; retry_room = room;
    kick(3'd1, 4, 6);
    client_mask = 16'h0F0F; reply_time = 8'd200;   // changed after sampling
    run_ticks(4);
    chk("R2", "host irq_start tick", t_st, 4);
    run_ticks(6);
    chk("R6", "txend tick", t_te, 6);
    chk("R6", "listen tick", t_ls, 6);
    chk("R6", "done count in data", c_dn, 0);
    run_ticks(exp_wait);
    chk("R6", "wait irq_start count", c_st, 1);
    chk("R6", "wait irq_start tick", t_st, exp_wait);
    run_ticks(132);
    chk("R7", "ack length done tick", t_dn, 132);
    chk("R7", "ack txend tick", t_te, 132);
    chk(exp_ack ? "R7" : "R8", "irq_ack count", c_ak, exp_ack);
    chk("R7", "busy end", busy, 0);
  endtask

  task automatic t_ignore;
    kick(3'd2, 5, 5);
    run_ticks(2);
    kick(3'd5, 1, 1);
    run_ticks(8);
    chk("R9", "irq_start tick", t_st, 3);
    chk("R9", "done tick", t_dn, 8);
    chk("R9", "done count", c_dn, 1);
  endtask

  task automatic t_zero;
    kick(3'd0, 0, 0);
    run_ticks(2);
    chk("R10", "irq_start tick", t_st, 1);
    chk("R10", "done tick", t_dn, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_quiet();
    t_host(16'hA005, 3, 1'b1, 1'b1, 164, 1);
    t_host(16'h0000, 7, 1'b0, 1'b1, 112, 0);
    t_host(16'hFFFF, 0, 1'b0, 1'b0, 272, 1);
    t_ignore();
    t_zero();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule